// File: doc/BRIEF.md
# Sixteen-Pin Configurable I/O Port

This block is a general-purpose I/O port with up to sixteen pins behind a small word-wide register interface. For each pin, software chooses a direction mode, an output type (push-pull or open-drain), a pull resistor and an output data bit. Each pin also has an external drive input, given as an enable and a value. Every cycle the block merges the register settings with the external drive into one resolved level per pin. That level appears on the pin's output line. The block registers the resolved levels, and the registered copy serves both as the input data register and as the memory of a floating pin.

The block flags external drive that conflicts with the output configuration. A push-pull output ignores any external drive. An open-drain output ignores an external high. The block reports both cases in a disconnect mask. A second mask marks the pins whose external drive is accepted and high. Some registers have no function in this block: output speed, port lock, the two alternate-function selectors and the analog switch. Writes to them are accepted and change no pin.

Top module: `gpio_port`

## Requirements
- R1: After reset the mode, speed and pull registers hold their parameter reset values, and the output-data and output-type registers read zero. With the default parameters every pin is an input with no pull, and every pin line and both masks read zero.
- R2: A pin in output mode (mode field 01) with output type 0 (push-pull) drives its line from its output-data bit and ignores external drive. When such a pin is externally driven, its disconnect-mask bit is set.
- R3: Output-data bits have no effect on pins whose mode is not 01.
- R4: On a pin in input mode (00), an enabled external drive sets the pin line to the drive value in the same cycle. The input data register (word index 4, byte offset 0x10) shows that level one clock later. A high accepted drive sets the pin's held-high mask bit.
- R5: Pins in alternate mode (10) or analog mode (11) behave exactly like input-mode pins.
- R6: An output-mode pin with output type 1 (open-drain) drives low when its data bit is 0. When its data bit is 1, it releases the line. An external low on an open-drain pin is accepted. An external high is rejected and sets the disconnect-mask bit.
- R7: If a pin has no active driver and no accepted external drive, a pull-up (pull field 01) gives a high level and a pull-down (10) gives a low level. Pull field 11 acts like 00 (no pull).
- R8: A pin with no driver, no accepted drive and no pull keeps the last level it resolved to.
- R9: Writes to the speed, lock, alternate-function and analog-switch registers, and to the read-only input data register, do not change any pin line or the input data register.
- R10: A pin's disconnect-mask bit and its held-high bit are never set together, and a pin can be disconnected only while its external drive is enabled.
- R11: Registers are word-wide at byte offsets 0x00 mode (2 bits per pin, pin n at bits 2n+1:2n), 0x04 output type, 0x08 speed, 0x0C pull (2 bits per pin), 0x10 input data, 0x14 output data, 0x18 lock, 0x1C and 0x20 alternate function, 0x2C analog switch. Speed reads back what was written; lock, alternate-function and analog-switch read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address of the register (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| ext_en | input | NUM_PINS | Per-pin external drive enable |
| ext_val | input | NUM_PINS | Per-pin external drive value |
| pin_level | output | NUM_PINS | Resolved level of each pin |
| disc_mask | output | NUM_PINS | Pins whose external drive is rejected |
| ext_high_mask | output | NUM_PINS | Pins whose external drive is accepted and high |

## Verification
The hardest case to reach is the held level of a floating pin. It depends on history, not on the current inputs. To reach it, the stimulus first forces a pin high or low, either with external drive or as an output. It waits one clock so the level is captured, and only then removes every source. The same history is built up before an open-drain pin is released, before a rejected external high is applied, and before the pull field is set to 11. In each case the bench expects the earlier level, not a default.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_IN  = 2'b00,
      PM_OUT = 2'b01,
      PM_ALT = 2'b10,
      PM_ANA = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      PL_NONE = 2'b00,
      PL_UP   = 2'b01,
      PL_DOWN = 2'b10,
      PL_RSVD = 2'b11
   } pin_pull_e;

   // word indices (byte offset / 4)
   localparam logic [3:0] WI_MODE  = 4'd0;
   localparam logic [3:0] WI_OTYPE = 4'd1;
   localparam logic [3:0] WI_SPEED = 4'd2;
   localparam logic [3:0] WI_PULL  = 4'd3;
   localparam logic [3:0] WI_IDR   = 4'd4;
   localparam logic [3:0] WI_ODR   = 4'd5;

endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
   import gpio_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       od_i,
   input  logic [1:0] pull_i,
   input  logic       odr_i,
   input  logic       ext_en_i,
   input  logic       ext_val_i,
   output logic       level_o,
   output logic       held_o,
   output logic       disc_o,
   output logic       ext_hi_o
);

   pin_mode_e mode;
   pin_pull_e pull;
   logic      is_out;
   logic      drv_act;
   logic      drv_val;
   logic      ext_rej;
   logic      ext_ok;

   assign mode    = pin_mode_e'(mode_i);
   assign pull    = pin_pull_e'(pull_i);
   assign is_out  = (mode == PM_OUT);
   // open-drain drives only while its data bit is low
   assign drv_act = is_out && (!od_i || !odr_i);
   assign drv_val = od_i ? 1'b0 : odr_i;
   // push-pull rejects everything, open-drain rejects a high
   assign ext_rej = ext_en_i && is_out && (!od_i || ext_val_i);
   assign ext_ok  = ext_en_i && !ext_rej;

   always_comb begin
      if (drv_act)             level_o = drv_val;
      else if (ext_ok)         level_o = ext_val_i;
      else if (pull == PL_UP)   level_o = 1'b1;
      else if (pull == PL_DOWN) level_o = 1'b0;
      else                     level_o = held_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_o <= 1'b0;
      else        held_o <= level_o;
   end

   assign disc_o   = ext_rej;
   assign ext_hi_o = ext_ok && ext_val_i;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS  = 16,
   parameter logic [31:0] MODE_RST  = 32'h0000_0000,
   parameter logic [31:0] SPEED_RST = 32'h0000_0000,
   parameter logic [31:0] PULL_RST  = 32'h0000_0000,
   localparam int unsigned FW       = 2 * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [5:0]          addr,
   input  logic [31:0]         wdata,
   input  logic [NUM_PINS-1:0] idr_i,
   output logic [FW-1:0]       mode_q,
   output logic [NUM_PINS-1:0] otype_q,
   output logic [FW-1:0]       pull_q,
   output logic [NUM_PINS-1:0] odr_q,
   output logic [31:0]         rdata
);

   logic [3:0]    widx;
   logic [FW-1:0] speed_q;

   assign widx = addr[5:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_RST[FW-1:0];
         speed_q <= SPEED_RST[FW-1:0];
         pull_q  <= PULL_RST[FW-1:0];
         otype_q <= '0;
         odr_q   <= '0;
      end else if (wr_en) begin
         case (widx)
            WI_MODE:  mode_q  <= wdata[FW-1:0];
            WI_OTYPE: otype_q <= wdata[NUM_PINS-1:0];
            WI_SPEED: speed_q <= wdata[FW-1:0];
            WI_PULL:  pull_q  <= wdata[FW-1:0];
            WI_ODR:   odr_q   <= wdata[NUM_PINS-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (widx)
         WI_MODE:  rdata = 32'(mode_q);
         WI_OTYPE: rdata = 32'(otype_q);
         WI_SPEED: rdata = 32'(speed_q);
         WI_PULL:  rdata = 32'(pull_q);
         WI_IDR:   rdata = 32'(idr_i);
         WI_ODR:   rdata = 32'(odr_q);
         default:  rdata = 32'h0;
      endcase
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS  = 16,
   parameter logic [31:0] MODE_RST  = 32'h0000_0000,
   parameter logic [31:0] SPEED_RST = 32'h0000_0000,
   parameter logic [31:0] PULL_RST  = 32'h0000_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [5:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] ext_en,
   input  logic [NUM_PINS-1:0] ext_val,
   output logic [NUM_PINS-1:0] pin_level,
   output logic [NUM_PINS-1:0] disc_mask,
   output logic [NUM_PINS-1:0] ext_high_mask
);

   localparam int unsigned FW = 2 * NUM_PINS;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 16) begin : g_bad_pins
         $error("gpio_port: NUM_PINS must be 1..16");
      end
   endgenerate

   logic [FW-1:0]       mode_q;
   logic [FW-1:0]       pull_q;
   logic [NUM_PINS-1:0] otype_q;
   logic [NUM_PINS-1:0] odr_q;
   logic [NUM_PINS-1:0] idr_q;

   gpio_port_regs #(
      .NUM_PINS  (NUM_PINS),
      .MODE_RST  (MODE_RST),
      .SPEED_RST (SPEED_RST),
      .PULL_RST  (PULL_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .idr_i   (idr_q),
      .mode_q  (mode_q),
      .otype_q (otype_q),
      .pull_q  (pull_q),
      .odr_q   (odr_q),
      .rdata   (bus_rdata)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         gpio_pin_resolve u_res (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode_q[2*p +: 2]),
            .od_i      (otype_q[p]),
            .pull_i    (pull_q[2*p +: 2]),
            .odr_i     (odr_q[p]),
            .ext_en_i  (ext_en[p]),
            .ext_val_i (ext_val[p]),
            .level_o   (pin_level[p]),
            .held_o    (idr_q[p]),
            .disc_o    (disc_mask[p]),
            .ext_hi_o  (ext_high_mask[p])
         );
      end
   endgenerate

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned NUM_PINS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [2*NUM_PINS-1:0] mode_q,
   input logic [NUM_PINS-1:0]   otype_q,
   input logic [2*NUM_PINS-1:0] pull_q,
   input logic [NUM_PINS-1:0]   odr_q,
   input logic [NUM_PINS-1:0]   idr_q,
   input logic [NUM_PINS-1:0]   ext_en,
   input logic [NUM_PINS-1:0]   ext_val,
   input logic [NUM_PINS-1:0]   pin_level,
   input logic [NUM_PINS-1:0]   disc_mask,
   input logic [NUM_PINS-1:0]   ext_high_mask
);

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_c
         assert_pp_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b01 && !otype_q[i]) |-> (pin_level[i] == odr_q[i]));

         assert_od_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b01 && otype_q[i] && !odr_q[i]) |-> !pin_level[i]);

         assert_in_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] != 2'b01 && ext_en[i]) |->
               (pin_level[i] == ext_val[i] && !disc_mask[i]));

         assert_idr_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (idr_q[i] == $past(pin_level[i])));

         assert_float_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] != 2'b01 && !ext_en[i] &&
             (pull_q[2*i +: 2] == 2'b00 || pull_q[2*i +: 2] == 2'b11))
               |-> (pin_level[i] == idr_q[i]));

         assert_mask_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
            disc_mask[i] |-> (ext_en[i] && !ext_high_mask[i]));
      end
   endgenerate

endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_q        (mode_q),
   .otype_q       (otype_q),
   .pull_q        (pull_q),
   .odr_q         (odr_q),
   .idr_q         (idr_q),
   .ext_en        (ext_en),
   .ext_val       (ext_val),
   .pin_level     (pin_level),
   .disc_mask     (disc_mask),
   .ext_high_mask (ext_high_mask)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] ext_en = '0;
   logic [15:0] ext_val = '0;
   logic [15:0] pin_level;
   logic [15:0] disc_mask;
   logic [15:0] ext_high_mask;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   string       q_tag[$];
   int          q_sel[$];
   logic [31:0] q_exp[$];

   always #5 clk = ~clk;

   gpio_port u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_wr        (bus_wr),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .ext_en        (ext_en),
      .ext_val       (ext_val),
      .pin_level     (pin_level),
      .disc_mask     (disc_mask),
      .ext_high_mask (ext_high_mask)
   );

   // sel: 0 pin_level, 1 disc_mask, 2 ext_high_mask, 3 bus_rdata
   task automatic push(input string tag, input int sel, input logic [31:0] exp);
      q_tag.push_back(tag);
      q_sel.push_back(sel);
      q_exp.push_back(exp);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic pins(input string tag, input logic [15:0] lv,
                       input logic [15:0] dm, input logic [15:0] hm);
      push(tag, 0, 32'(lv));
      push(tag, 1, 32'(dm));
      push(tag, 2, 32'(hm));
      step();
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
      bus_addr = a;
      push(tag, 3, exp);
      step();
   endtask

   // monitor: pops expected items and compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (q_sel.size() > 0) begin
            string       t;
            int          s;
            logic [31:0] e;
            logic [31:0] act;
            t = q_tag.pop_front();
            s = q_sel.pop_front();
            e = q_exp.pop_front();
            case (s)
               0:       act = 32'(pin_level);
               1:       act = 32'(disc_mask);
               2:       act = 32'(ext_high_mask);
               default: act = bus_rdata;
            endcase
            n_cmp++;
            if (act !== e) begin
               n_bad++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", t, s, act, e);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1 reset state
      pins("R1 reset pins", 16'h0, 16'h0, 16'h0);
      rd("R1 mode", 6'h00, 32'h0);
      rd("R1 pull", 6'h0C, 32'h0);
      rd("R1 speed", 6'h08, 32'h0);
      rd("R1 odr", 6'h14, 32'h0);
      rd("R1 otype", 6'h04, 32'h0);
      rd("R1 idr", 6'h10, 32'h0);
      // R11 map and readback
      wr(6'h04, 32'hFFFF_A5A5);
      rd("R11 otype", 6'h04, 32'h0000_A5A5);
      wr(6'h04, 32'h0);
      wr(6'h08, 32'h1234_5678);
      rd("R11 speed", 6'h08, 32'h1234_5678);
      wr(6'h18, 32'hFFFF_FFFF);
      rd("R11 lock reads zero", 6'h18, 32'h0);
      // R3 output data ignored on inputs
      wr(6'h14, 32'h0000_00FF);
      pins("R3 odr on inputs", 16'h0, 16'h0, 16'h0);
      rd("R3 odr readback", 6'h14, 32'h0000_00FF);
      // R2 push-pull outputs on pins 0,1
      wr(6'h00, 32'h0000_0005);
      pins("R2 push-pull drive", 16'h0003, 16'h0, 16'h0);
      ext_en = 16'h0001; ext_val = 16'h0000;
      pins("R2 ext ignored", 16'h0003, 16'h0001, 16'h0);
      ext_en = 16'h0;
      pins("R2 release", 16'h0003, 16'h0, 16'h0);
      // R6 open-drain
      wr(6'h04, 32'h0000_0003);
      pins("R6 released holds", 16'h0003, 16'h0, 16'h0);
      wr(6'h14, 32'h0000_00FE);
      pins("R6 od drives low", 16'h0002, 16'h0, 16'h0);
      ext_en = 16'h0002; ext_val = 16'h0000;
      pins("R6 ext low accepted", 16'h0000, 16'h0, 16'h0);
      ext_val = 16'h0002;
      pins("R6 ext high rejected", 16'h0000, 16'h0002, 16'h0);
      ext_en = 16'h0; ext_val = 16'h0;
      pins("R6 ext removed", 16'h0000, 16'h0, 16'h0);
      wr(6'h0C, 32'h0000_0004);
      pins("R6 released pull-up", 16'h0002, 16'h0, 16'h0);
      wr(6'h0C, 32'h0000_0005);
      pins("R6 driver beats pull", 16'h0002, 16'h0, 16'h0);
      // back to inputs with pull-ups on 0,1
      wr(6'h00, 32'h0);
      wr(6'h04, 32'h0);
      wr(6'h14, 32'h0);
      pins("R7 pull-up inputs", 16'h0003, 16'h0, 16'h0);
      // R4 input with external drive
      ext_en = 16'h0010; ext_val = 16'h0010;
      pins("R4 ext high on input", 16'h0013, 16'h0, 16'h0010);
      rd("R4 idr", 6'h10, 32'h0000_0013);
      // R8 hold after release
      ext_en = 16'h0; ext_val = 16'h0;
      pins("R8 floating holds high", 16'h0013, 16'h0, 16'h0);
      wr(6'h0C, 32'h0000_0205);
      pins("R7 pull-down", 16'h0003, 16'h0, 16'h0);
      wr(6'h0C, 32'h0000_0305);
      pins("R7 reserved pull holds low", 16'h0003, 16'h0, 16'h0);
      ext_en = 16'h0010; ext_val = 16'h0010;
      step();
      ext_en = 16'h0; ext_val = 16'h0;
      pins("R8 reserved pull holds high", 16'h0013, 16'h0, 16'h0);
      // R5 alternate on pin5, analog on pin6
      wr(6'h00, 32'h0000_3800);
      pins("R5 alt/analog float", 16'h0013, 16'h0, 16'h0);
      ext_en = 16'h0060; ext_val = 16'h0060;
      pins("R5 alt/analog follow ext", 16'h0073, 16'h0, 16'h0060);
      wr(6'h14, 32'h0000_0060);
      pins("R3 odr on alt/analog", 16'h0073, 16'h0, 16'h0060);
      rd("R5 idr", 6'h10, 32'h0000_0073);
      // R9 inert registers
      wr(6'h18, 32'hFFFF_FFFF);
      wr(6'h1C, 32'hFFFF_FFFF);
      wr(6'h20, 32'hFFFF_FFFF);
      wr(6'h2C, 32'hFFFF_FFFF);
      wr(6'h08, 32'hFFFF_FFFF);
      pins("R9 inert writes", 16'h0073, 16'h0, 16'h0060);
      wr(6'h10, 32'h0);
      rd("R9 idr not writable", 6'h10, 32'h0000_0073);
      rd("R9 afl reads zero", 6'h1C, 32'h0);
      rd("R9 asw reads zero", 6'h2C, 32'h0);
      step();
      step();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule